// File: doc/BRIEF.md
# Prescaled Input Glitch Filter

This block cleans up one input line before software or interrupt logic sees it. The raw pin first goes through a chain of synchronizer flops. A new synchronized level is then accepted as the filtered output only after it has differed from the current output for an unbroken window of clocks. Any return to the old level inside that window discards the candidate and the filtered output stays where it was.

The window length is set by two fields of the line's configuration word: a 4-bit repeat count and a 4-bit power-of-two prescale select. The window is count × 2^select clocks. The longest window is 15 × 2^15 = 491520 clocks, which is about 1.2 ms at a 2.5 ns clock, where 400 clocks make one microsecond. A count of zero turns the filter off, so the synchronized level is registered straight to the output. If the configuration word is zero while reset is held, the filter starts with a 144-clock window (select 4, count 9) and keeps it until the word takes a different value.

The filtered level is meant to feed the line's data-read path and its interrupt detector.

Top module: `gf_top`

## Requirements
- R1: The raw pin passes through 2 synchronizer flops (SYNC_STAGES). With filtering off, a pin change made before clock edge 1 reaches `pinFilt` after edge 3.
- R2: While `rstN` is low and after its release, `pinFilt` is 0 and all counters are cleared.
- R3: The window is N = count × 2^select clocks. The count is `cfgWord[7:4]` and the select is `cfgWord[11:8]`. A pin change held from before edge 1 appears on `pinFilt` after edge N+2.
- R4: A pin pulse that holds its new level for fewer than N edges leaves `pinFilt` unchanged. A pulse held for exactly N edges is accepted.
- R5: A count field of 0 disables filtering, so `pinFilt` follows the synchronized pin with one register of delay.
- R6: Bits of `cfgWord` outside [11:4] have no effect on the window length. Any change of the word, in any bit, still counts as a configuration change.
- R7: If `cfgWord` is zero while reset is held, the window is select 4 and count 9 (144 clocks). This setting lasts until `cfgWord` differs from its value at reset.
- R8: A change of `cfgWord` restarts the stability measurement, so the full new window is counted from the cycle after the change.
- R9: While the synchronized pin equals `pinFilt`, `pinFilt` does not change.
- R10: The largest select (15) works without counter overflow. Select 15 with count 1 gives a 32768-clock window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; `cfgWord` is sampled while it is low |
| pinRaw | input | 1 | Asynchronous raw pin level |
| cfgWord | input | CFG_W (12) | Line configuration word: count in [7:4], select in [11:8] |
| pinFilt | output | 1 | Filtered, synchronized pin level |

## Verification
With the default of two synchronizer stages, a pin change driven before an edge reaches the output exactly N+2 edges later. In bypass the delay is 3 edges. After a mid-window configuration change, the flip comes N edges after the edge that registers the change. The bench drives every stimulus on a falling edge and then counts rising edges, reading the output at the next falling edge until it flips. Each measured latency is compared with the value computed from count and select, so a result that arrives one cycle early or one cycle late is reported. Glitch checks hold the pin for exactly N−1 and N edges and then watch the output over a span longer than the window.

// File: rtl/gf_pkg.sv
package gf_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic restart;  // clear prescaler and stability counter
    logic accept;   // load synchronized level into the output
  } gfStrobe_t;
endpackage

// File: rtl/gf_ctrl.sv
module gf_ctrl
  import gf_pkg::*;
#(
  parameter int CFG_W   = 12,
  parameter int CNT_LSB = 4,
  parameter int CNT_W   = 4,
  parameter int SEL_LSB = 8,
  parameter int SEL_W   = 4,
  parameter int DEF_CNT = 9,
  parameter int DEF_SEL = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             syncIn,
  input  logic             filtOut,
  input  logic             preWrap,
  input  logic             stabLast,
  output logic [CNT_W-1:0] effCnt,
  output logic [SEL_W-1:0] effSel,
  output gfStrobe_t        strobe
);
  logic [CFG_W-1:0] prevCfg;
  logic             cfgChg;
  logic             mismatch;
  logic             bypass;
  logic [CNT_W-1:0] fieldCnt;
  logic [SEL_W-1:0] fieldSel;

  assign fieldCnt = cfgWord[CNT_LSB +: CNT_W];
  assign fieldSel = cfgWord[SEL_LSB +: SEL_W];
  assign cfgChg   = (cfgWord != prevCfg);
  assign mismatch = (syncIn != filtOut);
  assign bypass   = (effCnt == '0);

  always_ff @(posedge clk) begin
    prevCfg <= cfgWord;
    if (!rstN) begin
      if (cfgWord == '0) begin
        effCnt <= CNT_W'(DEF_CNT);
        effSel <= SEL_W'(DEF_SEL);
      end else begin
        effCnt <= fieldCnt;
        effSel <= fieldSel;
      end
    end else if (cfgChg) begin
      effCnt <= fieldCnt;
      effSel <= fieldSel;
    end
  end

  always_comb begin
    strobe.restart = cfgChg | ~mismatch;
    strobe.accept  = mismatch & (bypass | (preWrap & stabLast & ~cfgChg));
  end
endmodule

// File: rtl/gf_datapath.sv
module gf_datapath
  import gf_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4,
  parameter int SEL_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinRaw,
  input  logic [CNT_W-1:0] effCnt,
  input  logic [SEL_W-1:0] effSel,
  input  gfStrobe_t        strobe,
  output logic             syncIn,
  output logic             filtOut,
  output logic             preWrap,
  output logic             stabLast
);
  localparam int PRE_W = (1 << SEL_W) - 1;
  localparam logic [PRE_W-1:0] PRE_ONES = '1;

  logic [SYNC_STAGES-1:0] syncReg;
  logic [PRE_W-1:0]       preCnt;
  logic [PRE_W-1:0]       preMask;
  logic [CNT_W-1:0]       stabCnt;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk) syncReg[g] <= rstN ? pinRaw : 1'b0;
    end else begin : gNext
      always_ff @(posedge clk) syncReg[g] <= rstN ? syncReg[g-1] : 1'b0;
    end
  end

  assign syncIn   = syncReg[SYNC_STAGES-1];
  assign preMask  = ~(PRE_ONES << effSel);
  assign preWrap  = (preCnt == preMask);
  assign stabLast = (stabCnt == (effCnt - CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      stabCnt <= '0;
      filtOut <= 1'b0;
    end else if (strobe.accept) begin
      filtOut <= syncIn;
      preCnt  <= '0;
      stabCnt <= '0;
    end else if (strobe.restart) begin
      preCnt  <= '0;
      stabCnt <= '0;
    end else if (preWrap) begin
      preCnt  <= '0;
      stabCnt <= stabCnt + CNT_W'(1);
    end else begin
      preCnt  <= preCnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/gf_top.sv
module gf_top
  import gf_pkg::*;
#(
  parameter int CFG_W       = 12,
  parameter int CNT_LSB     = 4,
  parameter int CNT_W       = 4,
  parameter int SEL_LSB     = 8,
  parameter int SEL_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_CNT     = 9,
  parameter int DEF_SEL     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinRaw,
  input  logic [CFG_W-1:0] cfgWord,
  output logic             pinFilt
);
  logic             syncIn;
  logic             preWrap;
  logic             stabLast;
  logic [CNT_W-1:0] effCnt;
  logic [SEL_W-1:0] effSel;
  gfStrobe_t        strobe;

  gf_ctrl #(
    .CFG_W(CFG_W), .CNT_LSB(CNT_LSB), .CNT_W(CNT_W), .SEL_LSB(SEL_LSB),
    .SEL_W(SEL_W), .DEF_CNT(DEF_CNT), .DEF_SEL(DEF_SEL)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .syncIn(syncIn),
    .filtOut(pinFilt), .preWrap(preWrap), .stabLast(stabLast),
    .effCnt(effCnt), .effSel(effSel), .strobe(strobe)
  );

  gf_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W), .SEL_W(SEL_W)
  ) uData (
    .clk(clk), .rstN(rstN), .pinRaw(pinRaw), .effCnt(effCnt),
    .effSel(effSel), .strobe(strobe), .syncIn(syncIn), .filtOut(pinFilt),
    .preWrap(preWrap), .stabLast(stabLast)
  );
endmodule

// File: rtl/gf_checker.sv
module gf_checker #(
  parameter int CFG_W = 12,
  parameter int CNT_W = 4,
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [CFG_W-1:0] cfgWord,
  input logic             syncIn,
  input logic             filtOut,
  input logic [CNT_W-1:0] effCnt,
  input logic [SEL_W-1:0] effSel
);
  localparam int RUN_W = CNT_W + (1 << SEL_W);

  logic [CFG_W-1:0] cfgSeen;
  logic             lastFilt;
  logic [RUN_W-1:0] runLen;
  logic [RUN_W-1:0] window;
  logic             cfgMoved;

  assign window   = RUN_W'(effCnt) << effSel;
  assign cfgMoved = (cfgWord != cfgSeen);

  always_ff @(posedge clk) begin
    cfgSeen  <= cfgWord;
    lastFilt <= filtOut;
    if (!rstN || cfgMoved || (syncIn == filtOut)) runLen <= '0;
    else if (filtOut != lastFilt)                 runLen <= RUN_W'(1);
    else                                          runLen <= runLen + RUN_W'(1);
  end

  // R3
  flip_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (filtOut != $past(filtOut)) && ($past(effCnt) != '0) |-> runLen == $past(window));

  // R5
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (effCnt == '0) && (syncIn != filtOut) |=> filtOut == $past(syncIn));

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn == filtOut) |=> $stable(filtOut));

  // R4
  window_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (effCnt != '0) |-> runLen <= window);
endmodule

bind gf_top gf_checker #(.CFG_W(CFG_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) uChk (
  .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .syncIn(syncIn),
  .filtOut(pinFilt), .effCnt(effCnt), .effSel(effSel)
);

// File: tb/sim_gf_top.sv
module sim_gf_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pinRaw = 1'b0;
  logic [11:0] cfgWord = 12'h000;
  logic        pinFilt;
  int          nChecks = 0;
  int          nFail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  gf_top u0 (.clk(clk), .rstN(rstN), .pinRaw(pinRaw), .cfgWord(cfgWord), .pinFilt(pinFilt));

  task automatic check(input string tag, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic setCfg(input logic [11:0] w);
    cfgWord = w;
    cyc(2);
  endtask

  // toggle the pin and count edges until the output follows
  task automatic measure(input string tag, input int expLat, input int maxWait);
    logic tgt;
    int lat;
    tgt = ~pinFilt;
    pinRaw = tgt;
    lat = 0;
    do begin cyc(1); lat++; end while (pinFilt != tgt && lat <= maxWait);
    check(tag, lat, expLat);
  endtask

  initial begin
    int n;
    int lat;
    int flips;
    logic tgt;
    logic seen;
    logic ref0;
    cyc(4);
    check("R2 reset out", int'(pinFilt), 0);
    rstN = 1'b1;
    cyc(3);
    check("R2 after release", int'(pinFilt), 0);

    // R7 default window 144 from zero word at reset
    measure("R7 default window", 146, 400);
    // R6/R7/R5: spare bit alone is a change; count 0 bypass; R1 3-edge path
    setCfg(12'h001);
    measure("R5 R1 bypass latency", 3, 20);
    measure("R5 bypass other edge", 3, 20);

    // R3/R6 sweep of count and select, spare bits varied
    for (int s = 0; s < 4; s++) begin
      for (int c = 1; c < 16; c++) begin
        setCfg(12'((s << 8) | (c << 4) | ((c ^ s) & 4'hF)));
        measure($sformatf("R3 R6 cnt=%0d sel=%0d", c, s), (c << s) + 2, 200);
      end
    end
    setCfg(12'h4F0);
    measure("R3 cnt=15 sel=4", 242, 400);

    // R4 glitch shorter than N=20 ignored, length N accepted
    setCfg(12'h250);
    n = 20;
    ref0 = pinFilt;
    pinRaw = ~ref0;
    cyc(n - 1);
    pinRaw = ref0;
    flips = 0;
    for (int i = 0; i < 3 * n; i++) begin cyc(1); if (pinFilt != ref0) flips++; end
    check("R4 short glitch no change", flips, 0);
    pinRaw = ~ref0;
    cyc(n);
    pinRaw = ref0;
    seen = 0;
    for (int i = 0; i < 3 * n; i++) begin cyc(1); if (pinFilt != ref0) seen = 1; end
    check("R4 full-length pulse accepted", int'(seen), 1);
    check("R4 settles back", int'(pinFilt), int'(ref0));

    // R8 config change mid-window restarts: N=16, change after 10 edges
    setCfg(12'h240);
    tgt = ~pinFilt;
    pinRaw = tgt;
    cyc(10);
    cfgWord = 12'h241;
    lat = 10;
    do begin cyc(1); lat++; end while (pinFilt != tgt && lat <= 100);
    check("R8 restart on cfg change", lat, 27);

    // R9 hold while input matches output
    flips = 0;
    ref0 = pinFilt;
    for (int i = 0; i < 50; i++) begin cyc(1); if (pinFilt != ref0) flips++; end
    check("R9 hold stable", flips, 0);

    // R10 largest select
    setCfg(12'hF10);
    measure("R10 sel=15 cnt=1", 32770, 33000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule